// File: doc/BRIEF.md
# Serial Configuration Register Interface

This block is a write-only serial slave that loads a small bank of configuration registers. A host lowers an active-low select line, then clocks 24-bit words in on a serial data line, most significant bit first. Each word carries an 8-bit register address followed by 16 bits of data. The register bank drives parallel configuration buses that the rest of the chip reads directly.

The serial pins have no fixed relation to the system clock. They pass through a synchronizer and an edge detector, so the system clock has to run at least four times faster than the fastest serial clock. A word commits on every 24th serial clock rising edge inside one select window, so a host can stream several words back to back. Bits left over when the window closes are dropped.

Two paths return every register to its default value: a self-clearing command bit and an active-low reset pin. The synchronous system reset does the same.

Top module: `cfg_serial_regs`

## Requirements
- R1: Serial clock edges have no effect while `sel_n` is high. Only rising edges seen while `sel_n` is low shift data in.
- R2: `sdi` is sampled on each rising edge of `sck`, most significant bit first. Every 24th rising edge within one select window commits the assembled word.
- R3: The first 8 bits of a word are the address and the next 16 bits are the data. Addresses 0x10 to 0x17 select register k = address - 0x10, whose value appears on `cfg_regs_o[16*k +: 16]`.
- R4: Several words may be sent in one select window. When `sel_n` rises, any bits past the last complete 24-bit word are discarded and the bit count restarts from zero.
- R5: A word to address 0x00 with data bit 0 set loads every register with its default and raises `srst_o` for exactly one clock. The bit is not retained. A word to 0x00 with bit 0 clear changes nothing.
- R6: The default of register k is {8'hC0 + k, 8'h3A}. `rst` high, or `hw_rst_n` held low for at least 3 clocks, loads every default, and `srst_o` is low after reset.
- R7: Correct capture for any `sck` high and low times of at least 2 clocks each, whatever the duty cycle.
- R8: A word to any address other than 0x00 and 0x10 to 0x17 leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| hw_rst_n | input | 1 | Asynchronous active-low reset pin, synchronized inside |
| sel_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| cfg_regs_o | output | NUM_REGS*16 | Concatenated register values, register k at bits 16*k+15 down to 16*k |
| srst_o | output | 1 | One-clock pulse when the software reset command is taken |

## Verification
The bench goes after word framing. It sends a word of 23 bits followed by a close of the window, and it sends a full word with trailing bits. A design that counted across windows, or committed partial words, would corrupt a register.

It toggles the serial clock with the select line high. A design that shifted regardless of select would write a register.

It targets addresses just below and just above the implemented range. An address decode off by one would overwrite a neighbouring register.

It drives strongly asymmetric serial clock duty cycles. A design with a synchronizer or edge detector that missed short pulses would shift the wrong bits.

It checks the software reset command for a restore of the defaults, for exactly one pulse, and for a bit that does not stick.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
  localparam int CFGS_ADDR_W   = 8;
  localparam int CFGS_DATA_W   = 16;
  localparam int CFGS_WORD_W   = CFGS_ADDR_W + CFGS_DATA_W;
  localparam int CFGS_SRST_BIT = 0;

  // Power-on value of register k: upper byte counts up from C0, lower byte fixed.
  function automatic logic [CFGS_DATA_W-1:0] cfgs_default(input int k);
    return {8'hC0 + 8'(k), 8'h3A};
  endfunction
endpackage

// File: rtl/cfgs_sync.sv
module cfgs_sync #(
  parameter int             WIDTH   = 1,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= RST_VAL;
        else if (s == 0) stage_q[s] <= async_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfgs_rise.sv
module cfgs_rise (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/cfgs_shift.sv
module cfgs_shift
  import cfgs_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sel_n_s,
  input  logic                   sck_rise,
  input  logic                   sdi_s,
  output logic                   wr_en_o,
  output logic [CFGS_ADDR_W-1:0] wr_addr_o,
  output logic [CFGS_DATA_W-1:0] wr_data_o
);
  localparam int WORD_W = CFGS_WORD_W;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-2:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              take, at_last;

  assign take    = ~sel_n_s & sck_rise;
  assign at_last = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q      <= '0;
      cnt_q     <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (sel_n_s) begin
        cnt_q <= '0;
      end else if (sck_rise) begin
        sr_q <= {sr_q[WORD_W-3:0], sdi_s};
        if (at_last) begin
          cnt_q                  <= '0;
          wr_en_o                <= 1'b1;
          {wr_addr_o, wr_data_o} <= {sr_q, sdi_s};
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst) cnt_q <= LAST); // R2
  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (rst) sel_n_s |=> (cnt_q == '0)); // R4
  AST_COMMIT_ON_24TH: assert property (@(posedge clk) disable iff (rst) wr_en_o |-> $past(take && at_last)); // R2
  AST_NO_SHIFT_IDLE: assert property (@(posedge clk) disable iff (rst) (sel_n_s && !$past(wr_en_o)) |=> !wr_en_o); // R1
endmodule

// File: rtl/cfgs_regfile.sv
module cfgs_regfile
  import cfgs_pkg::*;
#(
  parameter int                     NUM_REGS  = 8,
  parameter logic [CFGS_ADDR_W-1:0] BASE_ADDR = 8'h10,
  parameter logic [CFGS_ADDR_W-1:0] CTRL_ADDR = 8'h00
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [CFGS_ADDR_W-1:0]          wr_addr,
  input  logic [CFGS_DATA_W-1:0]          wr_data,
  output logic [NUM_REGS*CFGS_DATA_W-1:0] regs_o,
  output logic                            srst_o
);
  localparam int DW = CFGS_DATA_W;
  localparam logic [CFGS_ADDR_W-1:0] LAST_ADDR = CFGS_ADDR_W'(BASE_ADDR + NUM_REGS - 1);

  logic [DW-1:0]          regs_q [NUM_REGS];
  logic [NUM_REGS*DW-1:0] dflt_flat;
  logic                   hit_ctrl, hit_reg;

  assign hit_ctrl = wr_en && (wr_addr == CTRL_ADDR) && wr_data[CFGS_SRST_BIT];
  assign hit_reg  = wr_en && (wr_addr >= BASE_ADDR) && (wr_addr <= LAST_ADDR);

  genvar k;
  generate
    for (k = 0; k < NUM_REGS; k++) begin : g_reg
      localparam logic [CFGS_ADDR_W-1:0] MY_ADDR = CFGS_ADDR_W'(BASE_ADDR + k);
      always_ff @(posedge clk) begin
        if (rst || hit_ctrl)                regs_q[k] <= cfgs_default(k);
        else if (wr_en && wr_addr == MY_ADDR) regs_q[k] <= wr_data;
      end
      assign regs_o[k*DW +: DW]    = regs_q[k];
      assign dflt_flat[k*DW +: DW] = cfgs_default(k);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) srst_o <= 1'b0;
    else     srst_o <= hit_ctrl;
  end

  AST_SRST_RESTORES: assert property (@(posedge clk) disable iff (rst) srst_o |-> (regs_o == dflt_flat)); // R5
  AST_SRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) srst_o |=> !srst_o); // R5
  AST_MISS_STABLE: assert property (@(posedge clk) disable iff (rst) (wr_en && !hit_reg && !hit_ctrl) |=> $stable(regs_o)); // R8
endmodule

// File: rtl/cfg_serial_regs.sv
module cfg_serial_regs
  import cfgs_pkg::*;
#(
  parameter int                     NUM_REGS    = 8,
  parameter logic [CFGS_ADDR_W-1:0] BASE_ADDR   = 8'h10,
  parameter int                     SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            hw_rst_n,
  input  logic                            sel_n,
  input  logic                            sck,
  input  logic                            sdi,
  output logic [NUM_REGS*CFGS_DATA_W-1:0] cfg_regs_o,
  output logic                            srst_o
);
  logic [3:0] pins_s;
  logic       hw_rst_n_s, sel_n_s, sck_s, sdi_s;
  logic       sck_rise, core_rst;
  logic                   wr_en;
  logic [CFGS_ADDR_W-1:0] wr_addr;
  logic [CFGS_DATA_W-1:0] wr_data;

  // All serial pins share one synchronizer so data stays aligned with its clock.
  cfgs_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .async_i({hw_rst_n, sel_n, sck, sdi}),
    .sync_o (pins_s)
  );
  assign {hw_rst_n_s, sel_n_s, sck_s, sdi_s} = pins_s;
  assign core_rst = rst | ~hw_rst_n_s;

  cfgs_rise u_rise (
    .clk   (clk),
    .rst   (core_rst),
    .lvl_i (sck_s),
    .rise_o(sck_rise)
  );

  cfgs_shift u_shift (
    .clk      (clk),
    .rst      (core_rst),
    .sel_n_s  (sel_n_s),
    .sck_rise (sck_rise),
    .sdi_s    (sdi_s),
    .wr_en_o  (wr_en),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data)
  );

  cfgs_regfile #(.NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR), .CTRL_ADDR(8'h00)) u_regs (
    .clk    (clk),
    .rst    (core_rst),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .regs_o (cfg_regs_o),
    .srst_o (srst_o)
  );
endmodule

// File: tb/cfg_serial_regs_tb.sv
`timescale 1ns/1ps
module cfg_serial_regs_tb;
  localparam int NR = 8;

  logic clk = 1'b0, rst = 1'b1, hw_rst_n = 1'b1, sel_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic [NR*16-1:0] cfg_regs_o;
  logic srst_o;
  int checks = 0, failures = 0, srst_pulses = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cfg_serial_regs u_dut (.clk(clk), .rst(rst), .hw_rst_n(hw_rst_n), .sel_n(sel_n),
    .sck(sck), .sdi(sdi), .cfg_regs_o(cfg_regs_o), .srst_o(srst_o));

  always @(posedge clk) if (srst_o) srst_pulses++;

  // {address, data, register index to check, expected value}
  localparam logic [42:0] VEC [6] = '{
    {8'h10, 16'h1234, 3'd0, 16'h1234},
    {8'h17, 16'hBEEF, 3'd7, 16'hBEEF},
    {8'h18, 16'hFFFF, 3'd7, 16'hBEEF},
    {8'h0F, 16'hAAAA, 3'd0, 16'h1234},
    {8'h00, 16'hFFFE, 3'd0, 16'h1234},
    {8'h13, 16'h0F0F, 3'd3, 16'h0F0F}
  };

  function automatic logic [15:0] dflt(input int k);
    return {8'hC0 + 8'(k), 8'h3A};
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] reg_of(input int k);
    return cfg_regs_o[k*16 +: 16];
  endfunction

  task automatic send_bits(input logic [63:0] bits, input int n, input int hi, input int lo);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i]; sck = 1'b0; wait_clk(lo);
      sck = 1'b1; wait_clk(hi);
    end
    sck = 1'b0; wait_clk(3);
  endtask

  task automatic open_win();  sel_n = 1'b0; wait_clk(3); endtask
  task automatic close_win(); sel_n = 1'b1; wait_clk(8); endtask

  task automatic word(input logic [7:0] a, input logic [15:0] d, input int hi, input int lo);
    open_win(); send_bits({40'd0, a, d}, 24, hi, lo); close_win();
  endtask

  task automatic all_defaults(input string tag);
    for (int k = 0; k < NR; k++) chk(tag, reg_of(k), dflt(k));
  endtask

  initial begin
    wait_clk(4); rst = 1'b0; wait_clk(4);
    // R6: reset state
    all_defaults("R6 reset defaults");
    chk("R6 srst_o low after reset", {15'd0, srst_o}, 16'd0);

    // R3/R5/R8: vector table, fastest legal sck (R2 msb-first framing)
    for (int v = 0; v < 6; v++) begin
      word(VEC[v][42:35], VEC[v][34:19], 2, 2);
      chk($sformatf("R3/R5/R8 table entry %0d", v), reg_of(int'(VEC[v][18:16])), VEC[v][15:0]);
    end
    chk("R5 bit0 clear no reset", reg_of(7), 16'hBEEF);

    // R4: two words in one window
    open_win();
    send_bits({16'd0, 8'h11, 16'h1111, 8'h12, 16'h2222}, 48, 2, 2);
    close_win();
    chk("R4 first word of window", reg_of(1), 16'h1111);
    chk("R4 second word of window", reg_of(2), 16'h2222);

    // R4: trailing bits dropped
    open_win();
    send_bits({6'd0, 8'h14, 16'h4444, 10'h3FF}, 34, 2, 2);
    close_win();
    chk("R4 full word before tail", reg_of(4), 16'h4444);
    open_win(); send_bits({40'd0, 8'h15, 16'h5555} >> 1, 23, 2, 2); close_win();
    chk("R4 23-bit partial ignored", reg_of(5), dflt(5));
    word(8'h15, 16'h5555, 2, 2);
    chk("R4 count restarts after window", reg_of(5), 16'h5555);

    // R1: sck toggling while deselected
    send_bits({40'd0, 8'h16, 16'h9999}, 24, 2, 2);
    wait_clk(8);
    chk("R1 no shift while sel_n high", reg_of(6), dflt(6));

    // R7: asymmetric duty cycles
    word(8'h16, 16'h6A6A, 2, 19);
    chk("R7 short high long low", reg_of(6), 16'h6A6A);
    word(8'h11, 16'h1A1A, 15, 2);
    chk("R7 long high short low", reg_of(1), 16'h1A1A);

    // R5: software reset command
    srst_pulses = 0;
    word(8'h00, 16'h0001, 2, 2);
    chk("R5 one srst pulse", 16'(srst_pulses), 16'd1);
    chk("R5 srst self clears", {15'd0, srst_o}, 16'd0);
    all_defaults("R5 soft reset defaults");

    // R6: hardware reset pin
    word(8'h12, 16'h7777, 2, 2);
    chk("R6 write before pin reset", reg_of(2), 16'h7777);
    hw_rst_n = 1'b0; wait_clk(4); hw_rst_n = 1'b1; wait_clk(6);
    chk("R6 pin reset restores", reg_of(2), dflt(2));
    word(8'h10, 16'h0BAD, 2, 2);
    chk("R6 usable after pin reset", reg_of(0), 16'h0BAD);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule